// File: doc/BRIEF.md
# Instruction Fetch Front End

This block is the first part of a five-stage in-order pipeline. It holds the program counter and the register that passes each fetched instruction to decode. Every clock it picks the next PC from three choices: hold, step by one instruction, or move by a signed branch displacement. In the same cycle it reads the instruction word at the current PC from a small local instruction store.

Decode, hazard detection and branch resolution are outside the block and feed it two control bits. A stall request freezes the pipeline front. A branch-taken flag redirects the PC and discards the word being fetched by loading a zero no-op in its place. The two controls take priority in a different order on each path. On the PC path a stall wins over a branch. On the instruction-register path a branch wins over a stall. The instruction store is filled through a simple synchronous write port.

Top module: `fetch_front`

## Requirements
- R1: While `rst` is high at a rising clock edge, the PC becomes 0 and the fetch register becomes the no-op word 32'h0000_0000.
- R2: When `stall_i` is high, the PC keeps its value, whatever `br_taken_i` is.
- R3: When `stall_i` is low and `br_taken_i` is high, the next PC is the current PC plus `br_offset_i`, read as a signed 32-bit byte displacement.
- R4: When both `stall_i` and `br_taken_i` are low, the next PC is the current PC plus 4.
- R5: When `br_taken_i` is high, the fetch register loads the no-op word 32'h0, even if `stall_i` is also high.
- R6: When `stall_i` is high and `br_taken_i` is low, the fetch register keeps its value.
- R7: When neither control is active, the fetch register loads the store word at index (PC >> 2) mod DEPTH, taken from the PC value before the edge. PC bits 1:0 play no part in the read.
- R8: When `imem_we_i` is high at an edge, the store word at `imem_waddr_i` takes the value `imem_wdata_i`. Later fetches of that index return the new word.
- R9: All PC arithmetic wraps modulo 2^32. For example, 0 plus a displacement of -4 gives 32'hFFFF_FFFC, and one step of 4 from there gives 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| stall_i | input | 1 | Freeze request from hazard detection |
| br_taken_i | input | 1 | Branch resolved as taken |
| br_offset_i | input | 32 | Signed byte displacement for a taken branch |
| imem_we_i | input | 1 | Instruction store write enable |
| imem_waddr_i | input | $clog2(DEPTH) | Instruction store word index to write |
| imem_wdata_i | input | 32 | Instruction word to write |
| pc_o | output | 32 | Current program counter |
| fir_o | output | 32 | Fetch-to-decode instruction register |

## Verification
Both the PC and the fetch register change on the first rising edge after their controls are applied. The fetch register holds the word at the PC as it stood before that edge. A store write is seen by a fetch at the next edge or later, never at the same edge. The bench drives controls on falling edges and compares both outputs with its own model on the following falling edge, one register stage later. The bench model updates its copy of the store only after it has computed the fetched word, so the fetch sees the same old-before-new order as the design.

// File: rtl/fe_pkg.sv
package fe_pkg;
  localparam int unsigned FE_XLEN  = 32;
  localparam int unsigned FE_STEP  = 4;
  localparam int unsigned FE_ALIGN = 2;

  typedef logic [FE_XLEN-1:0] word_t;

  localparam word_t FE_NOP = '0;

  // Next PC when the front advances on its own.
  function automatic word_t pc_seq(input word_t pc);
    return pc + word_t'(FE_STEP);
  endfunction

  // Next PC on a redirect; signed displacement, modulo 2^32.
  function automatic word_t pc_redirect(input word_t pc, input word_t disp);
    return pc + disp;
  endfunction

  // Word index of a byte address (low bits dropped).
  function automatic word_t word_of(input word_t pc);
    return pc >> FE_ALIGN;
  endfunction
endpackage

// File: rtl/fe_pc_unit.sv
module fe_pc_unit
  import fe_pkg::*;
(
  input  logic  clk,
  input  logic  rst,
  input  logic  stall,
  input  logic  br_taken,
  input  word_t br_disp,
  output word_t pc,
  output logic  ev_hold,
  output logic  ev_redirect,
  output logic  ev_seq
);
  word_t pc_q;
  word_t pc_d;

  // Stall has priority over a branch on this path.
  assign ev_hold     = stall;
  assign ev_redirect = !stall && br_taken;
  assign ev_seq      = !stall && !br_taken;

  always_comb begin
    pc_d = pc_q;
    if (ev_redirect)  pc_d = pc_redirect(pc_q, br_disp);
    else if (ev_seq)  pc_d = pc_seq(pc_q);
  end

  always_ff @(posedge clk) begin
    if (rst) pc_q <= '0;
    else     pc_q <= pc_d;
  end

  assign pc = pc_q;
endmodule

// File: rtl/fe_imem.sv
module fe_imem
  import fe_pkg::*;
#(
  parameter int unsigned DEPTH = 32,
  localparam int unsigned IDX_W = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             we,
  input  logic [IDX_W-1:0] waddr,
  input  word_t            wdata,
  input  logic [IDX_W-1:0] raddr,
  output word_t            rdata
);
  word_t store [DEPTH];

  always_ff @(posedge clk) begin
    if (we) store[waddr] <= wdata;
  end

  assign rdata = store[raddr];
endmodule

// File: rtl/fe_fir_unit.sv
module fe_fir_unit
  import fe_pkg::*;
(
  input  logic  clk,
  input  logic  rst,
  input  logic  stall,
  input  logic  br_taken,
  input  word_t fetched,
  output word_t fir,
  output logic  ev_squash,
  output logic  ev_freeze
);
  word_t fir_q;
  word_t fir_d;

  // Branch has priority over a stall on this path.
  assign ev_squash = br_taken;
  assign ev_freeze = !br_taken && stall;

  always_comb begin
    fir_d = fetched;
    if (ev_squash)      fir_d = FE_NOP;
    else if (ev_freeze) fir_d = fir_q;
  end

  always_ff @(posedge clk) begin
    if (rst) fir_q <= FE_NOP;
    else     fir_q <= fir_d;
  end

  assign fir = fir_q;
endmodule

// File: rtl/fetch_front.sv
module fetch_front
  import fe_pkg::*;
#(
  parameter int unsigned DEPTH = 32,
  localparam int unsigned IDX_W = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             stall_i,
  input  logic             br_taken_i,
  input  logic [31:0]      br_offset_i,
  input  logic             imem_we_i,
  input  logic [IDX_W-1:0] imem_waddr_i,
  input  logic [31:0]      imem_wdata_i,
  output logic [31:0]      pc_o,
  output logic [31:0]      fir_o
);
  word_t pc;
  word_t word_idx;
  word_t fetched;
  logic  ev_hold;
  logic  ev_redirect;
  logic  ev_seq;
  logic  ev_squash;
  logic  ev_freeze;

  fe_pc_unit u_pc (
    .clk         (clk),
    .rst         (rst),
    .stall       (stall_i),
    .br_taken    (br_taken_i),
    .br_disp     (br_offset_i),
    .pc          (pc),
    .ev_hold     (ev_hold),
    .ev_redirect (ev_redirect),
    .ev_seq      (ev_seq)
  );

  assign word_idx = word_of(pc);

  fe_imem #(.DEPTH(DEPTH)) u_mem (
    .clk   (clk),
    .we    (imem_we_i),
    .waddr (imem_waddr_i),
    .wdata (imem_wdata_i),
    .raddr (word_idx[IDX_W-1:0]),
    .rdata (fetched)
  );

  fe_fir_unit u_fir (
    .clk       (clk),
    .rst       (rst),
    .stall     (stall_i),
    .br_taken  (br_taken_i),
    .fetched   (fetched),
    .fir       (fir_o),
    .ev_squash (ev_squash),
    .ev_freeze (ev_freeze)
  );

  assign pc_o = pc;
endmodule

// File: rtl/fetch_front_chk.sv
module fetch_front_chk (
  input logic        clk,
  input logic        rst,
  input logic        stall,
  input logic        br,
  input logic [31:0] disp,
  input logic [31:0] pc,
  input logic [31:0] fir,
  input logic        ev_hold,
  input logic        ev_redirect,
  input logic        ev_seq,
  input logic        ev_squash,
  input logic        ev_freeze
);
  AST_RESET_STATE: assert property (@(posedge clk) rst |=> (pc == 32'h0 && fir == 32'h0)); // R1
  AST_STALL_HOLDS_PC: assert property (@(posedge clk) disable iff (rst) ev_hold |=> pc == $past(pc)); // R2
  AST_PC_ONE_CHOICE: assert property (@(posedge clk) disable iff (rst) $countones({ev_hold, ev_redirect, ev_seq}) == 1); // R2
  AST_REDIRECT_TARGET: assert property (@(posedge clk) disable iff (rst) ev_redirect |=> pc == $past(pc) + $past(disp)); // R3
  AST_SEQ_STEP: assert property (@(posedge clk) disable iff (rst) ev_seq |=> pc == $past(pc) + 32'd4); // R4
  AST_SQUASH_NOP: assert property (@(posedge clk) disable iff (rst) ev_squash |=> fir == 32'h0); // R5
  AST_BRANCH_BEATS_STALL: assert property (@(posedge clk) disable iff (rst) (stall && br) |=> fir == 32'h0); // R5
  AST_STALL_HOLDS_FIR: assert property (@(posedge clk) disable iff (rst) ev_freeze |=> $stable(fir)); // R6
endmodule

bind fetch_front fetch_front_chk u_chk (
  .clk         (clk),
  .rst         (rst),
  .stall       (stall_i),
  .br          (br_taken_i),
  .disp        (br_offset_i),
  .pc          (pc_o),
  .fir         (fir_o),
  .ev_hold     (ev_hold),
  .ev_redirect (ev_redirect),
  .ev_seq      (ev_seq),
  .ev_squash   (ev_squash),
  .ev_freeze   (ev_freeze)
);

// File: tb/tb_fetch_front.sv
`timescale 1ns/1ps
module tb_fetch_front;
  localparam int unsigned DEPTH = 32;
  localparam int unsigned IDX_W = $clog2(DEPTH);

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic             stall_i = 1'b0;
  logic             br_taken_i = 1'b0;
  logic [31:0]      br_offset_i = '0;
  logic             imem_we_i = 1'b0;
  logic [IDX_W-1:0] imem_waddr_i = '0;
  logic [31:0]      imem_wdata_i = '0;
  logic [31:0]      pc_o;
  logic [31:0]      fir_o;

  int n_chk = 0;
  int n_bad = 0;
  int cyc   = 0;

  logic [31:0] pc_m  = '0;
  logic [31:0] fir_m = '0;
  logic [31:0] mem_m [DEPTH];

  fetch_front #(.DEPTH(DEPTH)) dut (
    .clk          (clk),
    .rst          (rst),
    .stall_i      (stall_i),
    .br_taken_i   (br_taken_i),
    .br_offset_i  (br_offset_i),
    .imem_we_i    (imem_we_i),
    .imem_waddr_i (imem_waddr_i),
    .imem_wdata_i (imem_wdata_i),
    .pc_o         (pc_o),
    .fir_o        (fir_o)
  );

  always #10 clk = ~clk;  // 50 MHz

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 20000) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: run did not end (actual %0d cycles, expected fewer)", cyc);
      summary();
      $finish;
    end
  end

  task automatic check(input string tag, input string what, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, got, exp);
    end
  endtask

  // One clock: drive at the falling edge, model at the rising edge, compare at the next falling edge.
  task automatic step(input logic s, input logic b, input logic [31:0] o,
                      input logic w, input logic [IDX_W-1:0] wa, input logic [31:0] wd);
    logic [31:0] pc_n;
    logic [31:0] fir_n;
    string pt;
    string ft;
    stall_i = s; br_taken_i = b; br_offset_i = o;
    imem_we_i = w; imem_waddr_i = wa; imem_wdata_i = wd;
    @(posedge clk);
    if (rst) begin
      pc_n = '0; fir_n = '0; pt = "R1"; ft = "R1";
    end else begin
      if (s)      begin pc_n = pc_m;     pt = "R2"; end
      else if (b) begin pc_n = pc_m + o; pt = "R3"; end
      else        begin pc_n = pc_m + 32'd4; pt = "R4"; end
      if (b)      begin fir_n = 32'h0; ft = "R5"; end
      else if (s) begin fir_n = fir_m; ft = "R6"; end
      else        begin fir_n = mem_m[pc_m[IDX_W+1:2]]; ft = "R7"; end
    end
    if (w) mem_m[wa] = wd;
    pc_m = pc_n;
    fir_m = fir_n;
    @(negedge clk);
    check(pt, "pc", pc_o, pc_m);
    check(ft, "fir", fir_o, fir_m);
  endtask

  function automatic logic [31:0] pick_off(input int k);
    case (k % 8)
      0: return 32'd4;
      1: return -32'sd8;
      2: return 32'd12;
      3: return 32'd2;
      4: return -32'sd4;
      5: return 32'd64;
      6: return -32'sd128;
      default: return 32'd7;
    endcase
  endfunction

  function automatic logic [31:0] word_val(input int i);
    return 32'hA500_0000 ^ (i * 32'h0101_0101) ^ 32'(i + 1);
  endfunction

  initial begin
    @(negedge clk);
    // Reset, with the store filled during reset (R1, R8).
    rst = 1'b1;
    for (int i = 0; i < DEPTH; i++) step(1'b0, 1'b0, '0, 1'b1, IDX_W'(i), word_val(i));
    check("R1", "pc after reset", pc_o, 32'h0);
    check("R1", "fir after reset", fir_o, 32'h0);
    rst = 1'b0;

    // Straight-line fetch past the end of the store: index wraps (R4, R7, R8).
    for (int i = 0; i < DEPTH + 8; i++) step(1'b0, 1'b0, '0, 1'b0, '0, '0);

    // Sweep all control pairs with several displacements (R2, R3, R5, R6, R7).
    for (int i = 0; i < 256; i++)
      step(i[1], i[0] ^ i[3], pick_off(i >> 4), 1'b0, '0, '0);

    // Branch and stall together: PC holds, fir squashed (R2, R5).
    step(1'b1, 1'b0, '0, 1'b0, '0, '0);
    step(1'b1, 1'b1, 32'd40, 1'b0, '0, '0);
    check("R5", "fir branch over stall", fir_o, 32'h0);

    // Wrap through zero (R9).
    rst = 1'b1;
    step(1'b0, 1'b0, '0, 1'b0, '0, '0);
    rst = 1'b0;
    step(1'b0, 1'b1, -32'sd4, 1'b0, '0, '0);
    check("R9", "pc wrapped below zero", pc_o, 32'hFFFF_FFFC);
    step(1'b0, 1'b0, '0, 1'b0, '0, '0);
    check("R9", "pc wrapped to zero", pc_o, 32'h0);
    check("R7", "fir from top index", fir_o, word_val(DEPTH - 1));

    // Rewrite a word while stalled, then fetch it (R8).
    step(1'b1, 1'b0, '0, 1'b1, IDX_W'(1), 32'hDEAD_BEEF);
    step(1'b0, 1'b0, '0, 1'b0, '0, '0);
    step(1'b0, 1'b0, '0, 1'b0, '0, '0);
    check("R8", "rewritten word fetched", fir_o, 32'hDEAD_BEEF);

    summary();
    $finish;
  end
endmodule